// File: doc/BRIEF.md
# Pad-Row Hit Finder with Straight-Line Fit Accumulators

The block looks at one time bin of pedestal-subtracted amplitudes from a row of adjacent pad channels at a time. In each bin it finds local charge clusters that span three pads. For each cluster it measures a sub-pad position from the left, centre and right amplitudes and corrects that position through a fixed nonlinear table. It then adds the cluster's time bin, position and charge into one of a few fit units. Each fit unit holds the running sums that a downstream processor needs to solve a least-squares straight line. The processor only reads these sums. The block has no path for writing them.

An event starts with a one-cycle start pulse. The pulse clears every sum and resets the time-bin counter. Each later time-bin strobe presents a new set of amplitudes. Only bins whose index lies inside a programmable window contribute to the sums. Once the last bin of the window has been processed, a done flag is raised and stays high until the next start.

Control is one state machine with five states:
- `S_IDLE`: after reset, waiting for the first start pulse.
- `S_WAIT`: waiting for a strobe.
- `S_DIV`: the position dividers step, one quotient bit per cycle.
- `S_ACC`: a one-cycle add into the fit units.
- `S_DONE`: the window is finished.

The transitions are:
- Start, from any state, goes to `S_WAIT`.
- In `S_WAIT`, a strobe in the window that carries at least one hit goes to `S_DIV`.
- In `S_WAIT`, any other strobe at the window's last bin goes to `S_DONE`.
- After seven steps, `S_DIV` goes to `S_ACC`.
- `S_ACC` goes to `S_DONE` after the window's last bin and to `S_WAIT` otherwise.

Strobes must be at least ten clock cycles apart. The window and threshold must be held constant during an event.

Top module: `hitfit_accum`

## Requirements
- R1: After reset, every sum reads 0 and done is low. Strobes are ignored until the first start pulse.
- R2: A start pulse clears all sums of all fit units in the next cycle, drops done, and restarts time-bin numbering at 0.
- R3: Channel i (1 ≤ i ≤ NCH-2) qualifies as a hit when all of the following hold:
  - its amplitude C is strictly greater than its left neighbour L;
  - C is strictly greater than its right neighbour R;
  - L+C+R is strictly greater than the threshold.
- R4: At most NFIT hits per bin are kept. They are ranked by centre amplitude, largest first, and equal amplitudes are ordered by lower channel index first. The hit of rank k goes to fit unit k.
- R5: The raw offset is floor(64·(S+R−L)/S), where S = L+C+R. It is a 7-bit value, and 64 means the hit is centred on pad i.
- R6: The corrected position is p = k + floor(k·(127−k)/512) for raw offset k. The hit coordinate is Y = 128·i + p.
- R7: Each fit unit adds up the following, where X is the time-bin index and Q = S:
  - the hit count;
  - ΣX, ΣX² and ΣQ;
  - ΣY, ΣY² and ΣX·Y.
- R8: Only bins with win_lo ≤ X ≤ win_hi change the sums. Bins outside the window leave the sums unchanged.
- R9: Done rises once bin win_hi has been handled. It then holds, and further strobes are ignored until the next start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start-of-event pulse |
| tb_strobe | input | 1 | Time-bin strobe; amplitudes are valid in this cycle |
| amp | input | NCH×AW | Pedestal-subtracted channel amplitudes |
| win_lo | input | TBW | First time bin that accumulates |
| win_hi | input | TBW | Last time bin that accumulates |
| hit_thr | input | AW+2 | Threshold on the three-pad sum |
| fit_cnt | output | NFIT×SW | Hit count per fit unit |
| fit_sx | output | NFIT×SW | ΣX per unit |
| fit_sx2 | output | NFIT×SW | ΣX² per unit |
| fit_sy | output | NFIT×SW | ΣY per unit |
| fit_sy2 | output | NFIT×SW | ΣY² per unit |
| fit_sxy | output | NFIT×SW | ΣX·Y per unit |
| fit_sq | output | NFIT×SW | ΣQ per unit |
| done | output | 1 | Window finished |

## Verification
The assertions watch properties that must hold on every cycle:
- the captured candidates stay ordered by centre amplitude with no gaps;
- each divider remainder ends below its divisor;
- the sums change only in the add cycle or on a clear;
- a clear zeroes them;
- done drops only after a start pulse;
- the add cycle only ever occurs for an in-window bin.

Only the bench's scenarios can show the actual values. These include the quantised offset and table correction at hand-worked points and the choice among five competing hits. They also include the strictness of the threshold and the peak test, the exact bins counted by the window, and the ignoring of strobes before start and after done.

// File: rtl/hf_pkg.sv
`timescale 1ns/1ps
package hf_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WAIT,
        S_DIV,
        S_ACC,
        S_DONE
    } hf_state_e;

    // Position correction: k + floor(k*(127-k)/512)
    function automatic logic [6:0] pos_corr(input logic [6:0] k);
        logic [13:0] t;
        t = 14'(k) * 14'(7'd127 - k);
        return k + 7'(t >> 9);
    endfunction

endpackage

// File: rtl/hf_hit_select.sv
`timescale 1ns/1ps
module hf_hit_select #(
    parameter int NCH  = 21,
    parameter int AW   = 10,
    parameter int NFIT = 4,
    localparam int CHW  = $clog2(NCH),
    localparam int SUMW = AW + 2
) (
    input  logic [NCH-1:0][AW-1:0]  amp,
    input  logic [SUMW-1:0]         thr,
    output logic [NFIT-1:0]         slot_vld,
    output logic [NFIT-1:0][CHW-1:0] slot_ch,
    output logic [NFIT-1:0][AW-1:0] slot_l,
    output logic [NFIT-1:0][AW-1:0] slot_c,
    output logic [NFIT-1:0][AW-1:0] slot_r
);
    logic [NCH-1:0] qual;

    always_comb begin
        qual = '0;
        for (int i = 1; i < NCH - 1; i++) begin
            qual[i] = (amp[i] > amp[i-1]) && (amp[i] > amp[i+1]) &&
                      ((SUMW'(amp[i-1]) + SUMW'(amp[i]) + SUMW'(amp[i+1])) > thr);
        end
    end

    always_comb begin
        slot_vld = '0;
        slot_ch  = '0;
        slot_l   = '0;
        slot_c   = '0;
        slot_r   = '0;
        for (int i = 1; i < NCH - 1; i++) begin
            int rank;
            rank = 0;
            for (int j = 1; j < NCH - 1; j++) begin
                if (qual[j] && ((amp[j] > amp[i]) || ((amp[j] == amp[i]) && (j < i))))
                    rank++;
            end
            if (qual[i] && (rank < NFIT)) begin
                slot_vld[rank] = 1'b1;
                slot_ch[rank]  = CHW'(i);
                slot_l[rank]   = amp[i-1];
                slot_c[rank]   = amp[i];
                slot_r[rank]   = amp[i+1];
            end
        end
    end
endmodule

// File: rtl/hf_cog_div.sv
`timescale 1ns/1ps
module hf_cog_div #(
    parameter int AW = 10,
    parameter int QW = 7,
    localparam int SUMW = AW + 2,
    localparam int NW   = SUMW + QW,
    localparam int IW   = $clog2(QW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [IW-1:0] idx,
    input  logic [AW-1:0] l,
    input  logic [AW-1:0] c,
    input  logic [AW-1:0] r,
    input  logic          chk,
    output logic [QW-1:0] q
);
    logic [SUMW-1:0] s_in, den;
    logic [SUMW:0]   n0;
    logic [NW-1:0]   rem, cmp;

    assign s_in = SUMW'(l) + SUMW'(c) + SUMW'(r);
    assign n0   = (SUMW+1)'(s_in) + (SUMW+1)'(r) - (SUMW+1)'(l);
    assign cmp  = NW'(den) << idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem <= '0;
            den <= '0;
            q   <= '0;
        end else if (load) begin
            rem <= NW'(n0) << (QW - 1);
            den <= s_in;
            q   <= '0;
        end else if (step && (rem >= cmp)) begin
            rem    <= rem - cmp;
            q[idx] <= 1'b1;
        end
    end

    // R5
    cog_rem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk |-> (rem < NW'(den)));
endmodule

// File: rtl/hf_fit_sums.sv
`timescale 1ns/1ps
module hf_fit_sums #(
    parameter int NFIT = 4,
    parameter int SW   = 32,
    parameter int XW   = 5,
    parameter int YW   = 12,
    parameter int QSW  = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clr,
    input  logic                      acc,
    input  logic [NFIT-1:0]           vld,
    input  logic [XW-1:0]             x,
    input  logic [NFIT-1:0][YW-1:0]   y,
    input  logic [NFIT-1:0][QSW-1:0]  qs,
    output logic [NFIT-1:0][SW-1:0]   s_cnt,
    output logic [NFIT-1:0][SW-1:0]   s_x,
    output logic [NFIT-1:0][SW-1:0]   s_x2,
    output logic [NFIT-1:0][SW-1:0]   s_y,
    output logic [NFIT-1:0][SW-1:0]   s_y2,
    output logic [NFIT-1:0][SW-1:0]   s_xy,
    output logic [NFIT-1:0][SW-1:0]   s_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n || clr) begin
            s_cnt <= '0; s_x <= '0; s_x2 <= '0;
            s_y   <= '0; s_y2 <= '0; s_xy <= '0; s_q <= '0;
        end else if (acc) begin
            for (int g = 0; g < NFIT; g++) begin
                if (vld[g]) begin
                    s_cnt[g] <= s_cnt[g] + SW'(1);
                    s_x[g]   <= s_x[g]  + SW'(x);
                    s_x2[g]  <= s_x2[g] + SW'(x) * SW'(x);
                    s_y[g]   <= s_y[g]  + SW'(y[g]);
                    s_y2[g]  <= s_y2[g] + SW'(y[g]) * SW'(y[g]);
                    s_xy[g]  <= s_xy[g] + SW'(x) * SW'(y[g]);
                    s_q[g]   <= s_q[g]  + SW'(qs[g]);
                end
            end
        end
    end

    // R2
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> ((s_cnt == '0) && (s_q == '0) && (s_y2 == '0)));

    // R8
    sum_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !acc) |=> ($stable(s_cnt) && $stable(s_sy_sum_probe())));

    function automatic logic [NFIT*SW-1:0] s_sy_sum_probe();
        return s_y;
    endfunction
endmodule

// File: rtl/hitfit_accum.sv
`timescale 1ns/1ps
module hitfit_accum
    import hf_pkg::*;
#(
    parameter int NCH  = 21,
    parameter int AW   = 10,
    parameter int NFIT = 4,
    parameter int NTB  = 32,
    parameter int SW   = 32,
    localparam int TBW  = $clog2(NTB),
    localparam int SUMW = AW + 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    tb_strobe,
    input  logic [NCH-1:0][AW-1:0]  amp,
    input  logic [TBW-1:0]          win_lo,
    input  logic [TBW-1:0]          win_hi,
    input  logic [SUMW-1:0]         hit_thr,
    output logic [NFIT-1:0][SW-1:0] fit_cnt,
    output logic [NFIT-1:0][SW-1:0] fit_sx,
    output logic [NFIT-1:0][SW-1:0] fit_sx2,
    output logic [NFIT-1:0][SW-1:0] fit_sy,
    output logic [NFIT-1:0][SW-1:0] fit_sy2,
    output logic [NFIT-1:0][SW-1:0] fit_sxy,
    output logic [NFIT-1:0][SW-1:0] fit_sq,
    output logic                    done
);
    localparam int CHW = $clog2(NCH);
    localparam int QW  = 7;
    localparam int IW  = $clog2(QW);
    localparam int YW  = CHW + QW;

    hf_state_e state_q, state_d;

    logic [TBW-1:0] tb_cnt, tb_cur;
    logic [IW-1:0]  bit_idx;
    logic           in_win, cap_en;

    logic [NFIT-1:0]            sel_vld, cap_vld;
    logic [NFIT-1:0][CHW-1:0]   sel_ch, cap_ch;
    logic [NFIT-1:0][AW-1:0]    sel_l, sel_c, sel_r, cap_c;
    logic [NFIT-1:0][SUMW-1:0]  cap_sum;
    logic [NFIT-1:0][QW-1:0]    div_q;
    logic [NFIT-1:0][YW-1:0]    y_pos;

    assign in_win = (tb_cnt >= win_lo) && (tb_cnt <= win_hi);
    assign cap_en = (state_q == S_WAIT) && tb_strobe;

    hf_hit_select #(.NCH(NCH), .AW(AW), .NFIT(NFIT)) u_sel (
        .amp(amp), .thr(hit_thr), .slot_vld(sel_vld), .slot_ch(sel_ch),
        .slot_l(sel_l), .slot_c(sel_c), .slot_r(sel_r)
    );

    for (genvar k = 0; k < NFIT; k++) begin : g_div
        hf_cog_div #(.AW(AW), .QW(QW)) u_div (
            .clk(clk), .rst_n(rst_n), .load(cap_en), .step(state_q == S_DIV),
            .idx(bit_idx), .l(sel_l[k]), .c(sel_c[k]), .r(sel_r[k]),
            .chk((state_q == S_ACC) && cap_vld[k]), .q(div_q[k])
        );
        assign y_pos[k] = {cap_ch[k], pos_corr(div_q[k])};
    end

    hf_fit_sums #(.NFIT(NFIT), .SW(SW), .XW(TBW), .YW(YW), .QSW(SUMW)) u_sums (
        .clk(clk), .rst_n(rst_n), .clr(start), .acc(state_q == S_ACC),
        .vld(cap_vld), .x(tb_cur), .y(y_pos), .qs(cap_sum),
        .s_cnt(fit_cnt), .s_x(fit_sx), .s_x2(fit_sx2), .s_y(fit_sy),
        .s_y2(fit_sy2), .s_xy(fit_sxy), .s_q(fit_sq)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: ;
            S_WAIT: begin
                if (tb_strobe) begin
                    if (in_win && (|sel_vld)) state_d = S_DIV;
                    else if (tb_cnt == win_hi) state_d = S_DONE;
                end
            end
            S_DIV:  if (bit_idx == '0) state_d = S_ACC;
            S_ACC:  state_d = (tb_cur == win_hi) ? S_DONE : S_WAIT;
            S_DONE: ;
            default: state_d = S_IDLE;
        endcase
        if (start) state_d = S_WAIT;
    end

    // Datapath registers steered by the state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tb_cnt  <= '0;
            tb_cur  <= '0;
            bit_idx <= '0;
            cap_vld <= '0;
            cap_ch  <= '0;
            cap_c   <= '0;
            cap_sum <= '0;
        end else if (start) begin
            tb_cnt  <= '0;
            cap_vld <= '0;
        end else if (cap_en) begin
            tb_cnt  <= tb_cnt + TBW'(1);
            tb_cur  <= tb_cnt;
            bit_idx <= IW'(QW - 1);
            cap_vld <= in_win ? sel_vld : '0;
            cap_ch  <= sel_ch;
            cap_c   <= sel_c;
            for (int k = 0; k < NFIT; k++)
                cap_sum[k] <= SUMW'(sel_l[k]) + SUMW'(sel_c[k]) + SUMW'(sel_r[k]);
        end else if (state_q == S_DIV) begin
            bit_idx <= bit_idx - IW'(1);
        end
    end

    assign done = (state_q == S_DONE);

    for (genvar k = 1; k < NFIT; k++) begin : g_ord
        // R4
        sel_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ((state_q == S_DIV) && cap_vld[k]) |-> (cap_vld[k-1] && (cap_c[k-1] >= cap_c[k])));
    end

    // R9
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done) |-> $past(start));

    // R8
    acc_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ACC) |-> ((tb_cur >= win_lo) && (tb_cur <= win_hi)));

    // R1
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE) |-> ((fit_cnt == '0) && !done));
endmodule

// File: tb/hitfit_accum_tb.sv
`timescale 1ns/1ps
module hitfit_accum_tb;
    localparam int NCH = 21, AW = 10, NFIT = 4, NTB = 32, SW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic tb_strobe = 1'b0;
    logic [NCH-1:0][AW-1:0] amp = '0;
    logic [4:0] win_lo = '0, win_hi = '0;
    logic [AW+1:0] hit_thr = '0;
    logic [NFIT-1:0][SW-1:0] fit_cnt, fit_sx, fit_sx2, fit_sy, fit_sy2, fit_sxy, fit_sq;
    logic done;

    always #2 clk = ~clk;

    hitfit_accum #(.NCH(NCH), .AW(AW), .NFIT(NFIT), .NTB(NTB), .SW(SW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .tb_strobe(tb_strobe), .amp(amp),
        .win_lo(win_lo), .win_hi(win_hi), .hit_thr(hit_thr),
        .fit_cnt(fit_cnt), .fit_sx(fit_sx), .fit_sx2(fit_sx2), .fit_sy(fit_sy),
        .fit_sy2(fit_sy2), .fit_sxy(fit_sxy), .fit_sq(fit_sq), .done(done)
    );

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    longint e_cnt[NFIT], e_sx[NFIT], e_sx2[NFIT], e_sy[NFIT], e_sy2[NFIT], e_sxy[NFIT], e_sq[NFIT];
    int bcnt = 0;
    bit running = 0;

    task automatic check(string tag, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int k = 0; k < NFIT; k++) begin
            e_cnt[k] = 0; e_sx[k] = 0; e_sx2[k] = 0; e_sy[k] = 0;
            e_sy2[k] = 0; e_sxy[k] = 0; e_sq[k] = 0;
        end
    endtask

    task automatic model_bin();
        int x;
        bit q[NCH];
        if (!running) return;
        x = bcnt;
        bcnt++;
        if (x >= int'(win_lo) && x <= int'(win_hi)) begin
            for (int i = 0; i < NCH; i++) q[i] = 0;
            for (int i = 1; i < NCH - 1; i++)
                q[i] = (amp[i] > amp[i-1]) && (amp[i] > amp[i+1]) &&
                       (int'(amp[i-1]) + int'(amp[i]) + int'(amp[i+1]) > int'(hit_thr));
            for (int i = 1; i < NCH - 1; i++) begin
                if (q[i]) begin
                    int rk, l, c, r, s, off, p, y;
                    rk = 0;
                    for (int j = 1; j < NCH - 1; j++)
                        if (q[j] && (amp[j] > amp[i] || (amp[j] == amp[i] && j < i))) rk++;
                    if (rk < NFIT) begin
                        l = amp[i-1]; c = amp[i]; r = amp[i+1];
                        s = l + c + r;
                        off = (64 * (s + r - l)) / s;
                        p = off + (off * (127 - off)) / 512;
                        y = 128 * i + p;
                        e_cnt[rk] += 1; e_sx[rk] += x; e_sx2[rk] += x * x;
                        e_sy[rk] += y; e_sy2[rk] += longint'(y) * y;
                        e_sxy[rk] += x * y; e_sq[rk] += s;
                    end
                end
            end
        end
        if (x == int'(win_hi)) running = 0;
    endtask

    task automatic check_sums(string tag);
        for (int k = 0; k < NFIT; k++) begin
            check({tag, " R7 cnt"}, fit_cnt[k], e_cnt[k]);
            check({tag, " R7 sx"},  fit_sx[k],  e_sx[k]);
            check({tag, " R7 sx2"}, fit_sx2[k], e_sx2[k]);
            check({tag, " R7 sy"},  fit_sy[k],  e_sy[k]);
            check({tag, " R7 sy2"}, fit_sy2[k], e_sy2[k]);
            check({tag, " R7 sxy"}, fit_sxy[k], e_sxy[k]);
            check({tag, " R7 sq"},  fit_sq[k],  e_sq[k]);
        end
    endtask

    task automatic peak(int ch, int l, int c, int r);
        amp[ch-1] = AW'(l); amp[ch] = AW'(c); amp[ch+1] = AW'(r);
    endtask

    task automatic send_bin();
        model_bin();
        @(negedge clk) tb_strobe = 1'b1;
        @(negedge clk) tb_strobe = 1'b0;
        repeat (11) @(negedge clk);
    endtask

    task automatic start_event(int lo, int hi, int thr);
        win_lo = 5'(lo); win_hi = 5'(hi); hit_thr = 12'(thr);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        model_clear();
        bcnt = 0;
        running = 1;
    endtask

    task automatic t_reset();
        check("R1 done after reset", done, 0);
        model_clear();
        check_sums("R1 reset");
        amp = '0; peak(5, 10, 100, 30);
        send_bin();
        check("R1 strobe before start cnt", fit_cnt[0], 0);
        check("R1 strobe before start done", done, 0);
    endtask

    task automatic t_single();
        start_event(0, 3, 50);
        amp = '0; peak(5, 10, 100, 30);
        send_bin();
        check("R6 Y for L10 C100 R30 at pad 5", fit_sy[0], 720);
        check("R9 done low mid-window", done, 0);
        amp = '0; send_bin();
        amp = '0; peak(12, 0, 400, 399); send_bin();
        amp = '0; peak(5, 30, 100, 10); send_bin();
        check("R9 done after last bin", done, 1);
        check_sums("single");
    endtask

    task automatic t_offset_edge();
        start_event(0, 0, 0);
        amp = '0; peak(3, 1022, 1023, 0);
        send_bin();
        check("R5 left-heavy offset gives Y", fit_sy[0], 421);
        check_sums("offset");
    endtask

    task automatic t_rank();
        start_event(0, 0, 10);
        amp = '0;
        peak(2, 1, 200, 1); peak(6, 1, 300, 1); peak(10, 1, 300, 1);
        peak(14, 1, 100, 1); peak(18, 1, 250, 1);
        send_bin();
        check("R4 unit0 channel", fit_sy[0] >> 7, 6);
        check("R4 unit1 channel tie", fit_sy[1] >> 7, 10);
        check("R4 unit2 channel", fit_sy[2] >> 7, 18);
        check("R4 unit3 channel", fit_sy[3] >> 7, 2);
        check_sums("rank");
    endtask

    task automatic t_thresh();
        start_event(0, 2, 100);
        amp = '0; peak(4, 30, 40, 30); send_bin();
        check("R3 sum equal to threshold no hit", fit_cnt[0], 0);
        amp = '0; peak(4, 30, 41, 30); send_bin();
        check("R3 sum above threshold hit", fit_cnt[0], 1);
        amp = '0; peak(8, 50, 90, 90); send_bin();
        check("R3 plateau no hit", fit_cnt[0], 1);
        check_sums("thresh");
    endtask

    task automatic t_window();
        start_event(2, 4, 10);
        for (int b = 0; b < 5; b++) begin
            amp = '0; peak(7, 5, 60, 20);
            send_bin();
            if (b == 3) check("R9 done low before last bin", done, 0);
        end
        check("R8 count in window", fit_cnt[0], 3);
        check("R8 sum of X in window", fit_sx[0], 9);
        check("R9 done at win_hi", done, 1);
        for (int b = 0; b < 2; b++) begin
            amp = '0; peak(7, 5, 60, 20);
            send_bin();
        end
        check("R9 strobes after done ignored", fit_cnt[0], 3);
        check("R9 done held", done, 1);
        check_sums("window");
    endtask

    task automatic t_restart();
        start_event(0, 0, 10);
        check("R2 done cleared", done, 0);
        check("R2 count cleared", fit_cnt[0], 0);
        check("R2 charge cleared", fit_sq[0], 0);
        amp = '0; peak(9, 5, 60, 20);
        send_bin();
        check("R2 numbering restarts at 0", fit_sx[0], 0);
        check("R2 one hit after restart", fit_cnt[0], 1);
        check_sums("restart");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_offset_edge();
        t_rank();
        t_thresh();
        t_window();
        t_restart();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule